// File: doc/BRIEF.md
# Bubble-Collapsing Shift-Out FIFO

A small register-based queue meant for a router input port. Every incoming word is driven onto one input bus that reaches every storage cell. Only the free cell directly behind the run of held words captures it. When the consumer takes the head word, the occupied cells move one place toward the output and the free cells stay untouched. Because gaps never form inside the stored run, a word reaches the head after exactly as many reads as there are words ahead of it.

Both data sides use valid/ready handshakes.

- **Write side:** a word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only when the queue is full and the consumer is not reading in that same cycle.
- **Read side:** a word leaves on an edge where `out_valid` and `out_ready` are both high. `out_valid` is simply "not empty".
- **Stalls:** while the consumer holds `out_ready` low, the head word is kept stable.
- **Status:** a thermometer occupancy vector and the full and empty flags are brought out as plain status pins.

Top module: `collapse_fifo`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `occ` is all zero, `empty` is 1, `full` is 0 and `out_valid` is 0.
- R2: `occ` is thermometer coded. Bit 0 is the head cell, and bit k is 1 exactly when the queue holds more than k words.
- R3: No free cell ever lies between two held cells, so `occ` never has a 1 above a 0.
- R4: Whenever `out_valid` is 1, `out_data` is the oldest accepted word not yet read. Words leave in the order they were accepted.
- R5: A write alone raises the stored count by one, and a read alone lowers it by one.
- R6: A write and a read in the same cycle on a non-empty queue leave the count unchanged. The new word lands behind all remaining words.
- R7: `in_ready` equals `!full || out_ready`. A write to a full queue is taken only together with a read.
- R8: `out_valid` equals `!empty`. A write into an empty queue makes that word visible at `out_data` in the next cycle, and a read request in that cycle is refused.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_valid` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Queue can take the offered word |
| in_data | input | WIDTH | Word on the shared input bus |
| out_valid | output | 1 | Head word present |
| out_ready | input | 1 | Consumer takes the head word |
| out_data | output | WIDTH | Head cell contents |
| occ | output | DEPTH | Thermometer occupancy, bit 0 = head |
| full | output | 1 | All cells held |
| empty | output | 1 | No cell held |

## Verification
The bench builds the queue with DEPTH=4 and WIDTH=16. With only four cells, random traffic regularly reaches both the full and the empty boundaries. That makes a write plus read on a full queue and a write plus read on an empty queue frequent events rather than rare ones. Directed sequences also force those two cases, and a reference queue checks ordering through every cell.

// File: rtl/collapse_fifo_pkg.sv
package collapse_fifo_pkg;
  // per-cell action chosen by the occupancy controller
  typedef enum logic [1:0] {
    CELL_HOLD  = 2'd0,
    CELL_SHIFT = 2'd1,
    CELL_LOAD  = 2'd2
  } cell_op_e;
endpackage

// File: rtl/collapse_fifo_occ.sv
module collapse_fifo_occ
  import collapse_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  output logic [DEPTH-1:0] occ,
  output cell_op_e         cell_op [DEPTH]
);
  logic [DEPTH-1:0] occ_nxt;
  logic [DEPTH-1:0] occ_above;
  logic [DEPTH-1:0] occ_below;

  // neighbour views: cell above (farther from head), cell below (toward head)
  assign occ_above = {1'b0, occ[DEPTH-1:1]};
  assign occ_below = {occ[DEPTH-2:0], 1'b1};

  always_comb begin
    unique case ({push, pop})
      2'b10:   occ_nxt = occ | occ_below;
      2'b01:   occ_nxt = occ_above;
      default: occ_nxt = occ;
    endcase
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      cell_op[i] = CELL_HOLD;
      if (pop) begin
        // occupied cells move toward the head
        if (occ_above[i])
          cell_op[i] = CELL_SHIFT;
        else if (push && occ[i])
          cell_op[i] = CELL_LOAD;   // slot freed by the shift
      end else if (push && !occ[i] && occ_below[i]) begin
        cell_op[i] = CELL_LOAD;     // first free cell behind the run
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) occ <= '0;
    else     occ <= occ_nxt;
  end
endmodule

// File: rtl/collapse_fifo_cell.sv
module collapse_fifo_cell
  import collapse_fifo_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  cell_op_e         op,
  input  logic [WIDTH-1:0] bus_in,
  input  logic [WIDTH-1:0] next_in,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    unique case (op)
      CELL_LOAD:  q <= bus_in;
      CELL_SHIFT: q <= next_in;
      default:    q <= q;
    endcase
  end
endmodule

// File: rtl/collapse_fifo.sv
module collapse_fifo
  import collapse_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data,
  output logic [DEPTH-1:0] occ,
  output logic             full,
  output logic             empty
);
  logic             push;
  logic             pop;
  cell_op_e         cell_op [DEPTH];
  logic [WIDTH-1:0] cell_q  [DEPTH];

  assign full      = occ[DEPTH-1];
  assign empty     = ~occ[0];
  assign out_valid = occ[0];
  assign in_ready  = ~full | out_ready;
  assign pop       = out_valid & out_ready;
  assign push      = in_valid & in_ready;
  assign out_data  = cell_q[0];

  collapse_fifo_occ #(.DEPTH(DEPTH)) u_occ (
    .clk     (clk),
    .rst     (rst),
    .push    (push),
    .pop     (pop),
    .occ     (occ),
    .cell_op (cell_op)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    logic [WIDTH-1:0] nxt;
    if (g == DEPTH-1) begin : g_top
      assign nxt = '0;
    end else begin : g_mid
      assign nxt = cell_q[g+1];
    end
    collapse_fifo_cell #(.WIDTH(WIDTH)) u_cell (
      .clk     (clk),
      .op      (cell_op[g]),
      .bus_in  (in_data),
      .next_in (nxt),
      .q       (cell_q[g])
    );
  end
endmodule

// File: rtl/collapse_fifo_chk.sv
module collapse_fifo_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_data,
  input logic [DEPTH-1:0] occ,
  input logic             full,
  input logic             empty
);
  logic push_c, pop_c;
  assign push_c = in_valid & in_ready;
  assign pop_c  = out_valid & out_ready;

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (occ == '0));

  // R3
  no_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (((occ >> 1) & ~occ) == '0));

  // R5
  push_grow_chk: assert property (@(posedge clk) disable iff (rst)
    (push_c && !pop_c) |=> ($countones(occ) == $countones($past(occ)) + 1));

  // R5
  pop_shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_c && !push_c) |=> ($countones(occ) == $countones($past(occ)) - 1));

  // R6
  both_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_c && push_c) |=> $stable(occ));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !out_ready) |-> !in_ready);

  // R8
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    empty |-> !out_valid);

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

bind collapse_fifo collapse_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .occ       (occ),
  .full      (full),
  .empty     (empty)
);

// File: tb/collapse_fifo_tb.sv
module collapse_fifo_tb;
  localparam int D = 4;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_data = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [W-1:0] out_data;
  logic [D-1:0] occ;
  logic         full, empty;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 1'b0;
  logic [W-1:0] model[$];
  logic [W-1:0] tag = 16'h1000;

  always #5 clk = ~clk;

  collapse_fifo #(.DEPTH(D), .WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .occ(occ), .full(full), .empty(empty)
  );

  function automatic logic [D-1:0] thermo(input int n);
    logic [D-1:0] t = '0;
    for (int k = 0; k < D; k++) if (k < n) t[k] = 1'b1;
    return t;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, check settled outputs, update model at posedge
  task automatic step(input bit iv, input bit rr);
    int n;
    bit e_ready, do_push, do_pop;
    n = model.size();
    in_valid = iv; out_ready = rr; in_data = tag;
    #1;
    e_ready = (n < D) || rr;
    chk("R2 occ", 32'(occ), 32'(thermo(n)));
    chk("R3 contiguous", 32'(((occ >> 1) & ~occ)), 32'd0);
    chk("R7 in_ready", 32'(in_ready), 32'(e_ready));
    chk("R8 out_valid", 32'(out_valid), 32'(n > 0));
    chk("R7 full", 32'(full), 32'(n == D));
    chk("R8 empty", 32'(empty), 32'(n == 0));
    if (n > 0) chk("R4 head order", 32'(out_data), 32'(model[0]));
    do_push = iv && e_ready;
    do_pop  = rr && (n > 0);
    @(posedge clk);
    if (do_pop) void'(model.pop_front());
    if (do_push) begin model.push_back(tag); tag = tag + 16'h1; end
    @(negedge clk);
    if (do_push && !do_pop)
      chk("R5 push grows", 32'(model.size()), 32'(n + 1));
    if (do_pop && do_push)
      chk("R6 both keeps count", 32'(model.size()), 32'(n));
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 occ", 32'(occ), 32'd0);
    chk("R1 empty", 32'(empty), 32'd1);
    chk("R1 full", 32'(full), 32'd0);
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    rst = 1'b0;
    #1;
    chk("R1 after release", 32'(occ), 32'd0);
    @(negedge clk);

    // R8: push and pop on empty queue, pop refused, word at head next cycle
    step(1'b1, 1'b1);
    chk("R8 empty push visible", 32'(out_data), 32'(model[0]));
    step(1'b0, 1'b0);
    step(1'b0, 1'b1);

    // fill to full, R7 refused write without read
    for (int k = 0; k < D; k++) step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    chk("R7 full refuses", 32'(model.size()), 32'(D));
    // R9: stall holds head
    step(1'b0, 1'b0);
    // R6/R7: push+pop while full
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    // drain; R5 pop shrinks
    for (int k = 0; k < D; k++) step(1'b0, 1'b1);
    chk("R5 drained", 32'(occ), 32'd0);
    step(1'b0, 1'b1);

    // random phases: filling, draining, balanced
    for (int ph = 0; ph < 12; ph++) begin
      for (int k = 0; k < 250; k++) begin
        int r = $urandom_range(0, 99);
        int pw = (ph % 3 == 0) ? 80 : (ph % 3 == 1) ? 25 : 50;
        int pr = (ph % 3 == 0) ? 30 : (ph % 3 == 1) ? 80 : 50;
        step(r < pw, $urandom_range(0, 99) < pr);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule